// File: doc/BRIEF.md
# Flash Array Erase Sequencer

This block carries out the erase half of a serial NOR flash command set on a byte-wide storage array held beside it. A command front end presents an erase opcode together with a start address for one cycle. The sequencer decodes the opcode into an erase length and checks the write-enable latch and the device's erase capabilities. It then aligns the address down to the erase size and sweeps the region, writing the erased value 0xFF to one byte per clock through a synchronous memory write port.

The region sizes are parameters. The two smaller block sizes default to 16 and 64 bytes. A production part would use 4096 and 32768 bytes. The sector size and sector count are separate parameters. Two enable parameters state whether the device supports the two small sizes. An erase of a size the device lacks is still carried out, and an error flag is raised when it completes. A request that arrives while the write-enable latch is clear touches no byte. It ends at once with a write-protect error.

Top module: `nor_erase_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err_wp`, `err_size` and `mem_we` are all 0.
- R2: Opcodes 0x20 and 0x21 erase `SMALL_BYTES` bytes. The region starts at `req_addr` rounded down to a multiple of `SMALL_BYTES`.
- R3: Opcode 0x52 erases `MID_BYTES` bytes. The region starts at `req_addr` rounded down to a multiple of `MID_BYTES`.
- R4: Opcodes 0xD8 and 0xDC erase one sector of `SECTOR_BYTES` bytes. The region starts at `req_addr` rounded down to a multiple of `SECTOR_BYTES`.
- R5: Opcode 0xC7 erases the whole array from address 0, whatever `req_addr` holds.
- R6: During an erase, `mem_we` is high on exactly as many consecutive cycles as the region has bytes. `mem_addr` rises by one each cycle from the region base, `mem_wdata` is 0xFF, and `busy` equals `mem_we`. `busy` rises on the cycle after the request.
- R7: If `wel` is 0 when an erase opcode is requested, no byte is written. `done` and `err_wp` pulse together on the cycle after the request.
- R8: If 0x20/0x21 is requested with `HAS_SMALL`=0, or 0x52 with `HAS_MID`=0, `err_size` pulses together with `done`. The erase still runs when `wel` is 1.
- R9: Sector and whole-array erases never raise `err_size`.
- R10: A request presented while `busy` is high is ignored. The running erase continues unchanged.
- R11: An opcode outside the erase set is ignored: no write, no `busy` and no `done`.
- R12: `done` pulses for one cycle on the cycle after the last byte is written, and `busy` is low on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request strobe, one cycle |
| req_opcode | input | 8 | Erase opcode |
| req_addr | input | AW | Start address (AW = clog2 of array bytes) |
| wel | input | 1 | Write-enable latch state |
| busy | output | 1 | High while the region is being written |
| done | output | 1 | One-cycle completion pulse |
| err_wp | output | 1 | Write-protect error, pulses with `done` |
| err_size | output | 1 | Unsupported erase size, pulses with `done` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bound checker covers several properties on every cycle. It checks that each write carries 0xFF, that `busy` tracks `mem_we`, and that addresses step by one with no restart while a sweep runs. It also checks that every fall of `busy` is met by `done` and that error pulses only appear alongside `done`. The array contents can only be shown by the bench's scenarios, which check them against a model memory filled with a known pattern. Those scenarios cover the aligned base and length chosen for each opcode, the whole-array sweep, the protected case that leaves the pattern intact, and the ignored unknown and overlapping requests.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
  localparam logic [7:0] OP_SMALL_A  = 8'h20;
  localparam logic [7:0] OP_SMALL_B  = 8'h21;
  localparam logic [7:0] OP_MID      = 8'h52;
  localparam logic [7:0] OP_SECTOR_A = 8'hD8;
  localparam logic [7:0] OP_SECTOR_B = 8'hDC;
  localparam logic [7:0] OP_WHOLE    = 8'hC7;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    EK_NONE, EK_SMALL, EK_MID, EK_SECTOR, EK_WHOLE
  } erase_kind_e;
endpackage

// File: rtl/nor_erase_decode.sv
module nor_erase_decode
  import nor_erase_pkg::*;
#(
  parameter int SMALL_BYTES  = 16,
  parameter int MID_BYTES    = 64,
  parameter int SECTOR_BYTES = 128,
  parameter int SECTOR_COUNT = 4,
  parameter bit HAS_SMALL    = 1'b1,
  parameter bit HAS_MID      = 1'b0,
  parameter int AW           = $clog2(SECTOR_BYTES * SECTOR_COUNT)
) (
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic          unsup,
  output logic [AW-1:0] base,
  output logic [AW-1:0] len_m1
);
  localparam int TOTAL_BYTES = SECTOR_BYTES * SECTOR_COUNT;
  localparam logic [AW-1:0] SMALL_M1  = AW'(SMALL_BYTES - 1);
  localparam logic [AW-1:0] MID_M1    = AW'(MID_BYTES - 1);
  localparam logic [AW-1:0] SECTOR_M1 = AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] TOTAL_M1  = AW'(TOTAL_BYTES - 1);

  erase_kind_e kind;

  always_comb begin
    unique case (opcode)
      OP_SMALL_A, OP_SMALL_B:   kind = EK_SMALL;
      OP_MID:                   kind = EK_MID;
      OP_SECTOR_A, OP_SECTOR_B: kind = EK_SECTOR;
      OP_WHOLE:                 kind = EK_WHOLE;
      default:                  kind = EK_NONE;
    endcase
  end

  always_comb begin
    hit    = 1'b1;
    unsup  = 1'b0;
    len_m1 = '0;
    base   = '0;
    unique case (kind)
      EK_SMALL: begin
        len_m1 = SMALL_M1;
        unsup  = !HAS_SMALL;
      end
      EK_MID: begin
        len_m1 = MID_M1;
        unsup  = !HAS_MID;
      end
      EK_SECTOR: len_m1 = SECTOR_M1;
      EK_WHOLE:  len_m1 = TOTAL_M1;
      default:   hit = 1'b0;
    endcase
    // Sizes are powers of two, so masking with the inverted length aligns down.
    if (kind != EK_WHOLE) base = addr & ~len_m1;
  end
endmodule

// File: rtl/nor_erase_walker.sv
module nor_erase_walker
  import nor_erase_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic [AW-1:0] start_len_m1,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [7:0]    wdata,
  output logic          last
);
  logic [AW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      we     <= 1'b0;
      addr   <= '0;
      remain <= '0;
      wdata  <= 8'h00;
    end else if (start) begin
      we     <= 1'b1;
      addr   <= start_base;
      remain <= start_len_m1;
      wdata  <= ERASED_BYTE;
    end else if (we) begin
      if (remain == '0) begin
        we <= 1'b0;
      end else begin
        addr   <= addr + 1'b1;
        remain <= remain - 1'b1;
      end
    end
  end

  assign last = we && (remain == '0);
endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine
  import nor_erase_pkg::*;
#(
  parameter int SMALL_BYTES  = 16,
  parameter int MID_BYTES    = 64,
  parameter int SECTOR_BYTES = 128,
  parameter int SECTOR_COUNT = 4,
  parameter bit HAS_SMALL    = 1'b1,
  parameter bit HAS_MID      = 1'b0,
  parameter int AW           = $clog2(SECTOR_BYTES * SECTOR_COUNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [7:0]    req_opcode,
  input  logic [AW-1:0] req_addr,
  input  logic          wel,
  output logic          busy,
  output logic          done,
  output logic          err_wp,
  output logic          err_size,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  logic          dec_hit, dec_unsup;
  logic [AW-1:0] dec_base, dec_len_m1;
  logic          accept, start, last;
  logic          size_pend;

  nor_erase_decode #(
    .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .SECTOR_COUNT(SECTOR_COUNT),
    .HAS_SMALL(HAS_SMALL), .HAS_MID(HAS_MID), .AW(AW)
  ) u_decode (
    .opcode(req_opcode), .addr(req_addr),
    .hit(dec_hit), .unsup(dec_unsup),
    .base(dec_base), .len_m1(dec_len_m1)
  );

  assign accept = req_valid && dec_hit && !mem_we;
  assign start  = accept && wel;

  nor_erase_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst(rst), .start(start),
    .start_base(dec_base), .start_len_m1(dec_len_m1),
    .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      err_wp    <= 1'b0;
      err_size  <= 1'b0;
      size_pend <= 1'b0;
    end else begin
      done     <= (accept && !wel) || last;
      err_wp   <= accept && !wel;
      err_size <= (accept && !wel && dec_unsup) || (last && size_pend);
      if (start) size_pend <= dec_unsup;
    end
  end

  assign busy = mem_we;
endmodule

// File: rtl/nor_erase_engine_chk.sv
module nor_erase_engine_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err_wp,
  input logic          err_size,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata
);
  // R1: cleared outputs on the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !busy && !done && !err_wp && !err_size && !mem_we);

  // R6: every write carries the erased value
  a_r6_fill_ff: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == 8'hFF);

  // R6: busy tracks the write strobe
  a_r6_busy_we: assert property (@(posedge clk) disable iff (rst)
    busy == mem_we);

  // R10: a running sweep steps by one and never restarts
  a_r10_steady_walk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> mem_addr == $past(mem_addr) + 1'b1);

  // R12: the end of a sweep is marked by done
  a_r12_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7: a protect error is a completion with no sweep
  a_r7_wp_idle: assert property (@(posedge clk) disable iff (rst)
    err_wp |-> done && !busy);

  // R8: size error only alongside completion
  a_r8_size_done: assert property (@(posedge clk) disable iff (rst)
    err_size |-> done);
endmodule

bind nor_erase_engine nor_erase_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err_wp(err_wp),
  .err_size(err_size), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/tb_nor_erase_engine.sv
module tb_nor_erase_engine;
  localparam int AW    = 9;
  localparam int TOTAL = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [7:0]    req_opcode = 8'h00;
  logic [AW-1:0] req_addr = '0;
  logic          wel = 1'b0;
  logic          busy, done, err_wp, err_size, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  int checks = 0;
  int errors = 0;

  nor_erase_engine dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .wel(wel), .busy(busy), .done(done),
    .err_wp(err_wp), .err_size(err_size), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #10 clk = ~clk;

  // model memory and write log
  logic [7:0] mem [TOTAL];
  int wr_count;
  int wr_first;
  int wr_prev;
  int wr_bad;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (wr_count == 0) wr_first = int'(mem_addr);
      else if (int'(mem_addr) != wr_prev + 1) wr_bad++;
      if (mem_wdata != 8'hFF) wr_bad++;
      wr_prev = int'(mem_addr);
      wr_count++;
    end
  end

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 7 + 1) & 8'h7F);
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic prepare();
    @(negedge clk);
    for (int i = 0; i < TOTAL; i++) mem[i] = pattern(i);
    wr_count = 0;
    wr_bad   = 0;
    wr_first = -1;
  endtask

  task automatic check_array(string req, int base, int len);
    int bad = 0;
    for (int i = 0; i < TOTAL; i++) begin
      logic [7:0] exp_b;
      exp_b = (i >= base && i < base + len) ? 8'hFF : pattern(i);
      if (mem[i] !== exp_b) bad++;
    end
    check(req, bad, 0);
  endtask

  // Issue a request and follow it to completion.
  task automatic run_erase(string req, logic [7:0] op, int addr, logic en,
                           int exp_base, int exp_len, logic exp_wp,
                           logic exp_sz);
    int cycles = 0;
    prepare();
    req_valid  = 1'b1;
    req_opcode = op;
    req_addr   = AW'(addr);
    wel        = en;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && cycles < 4000) begin
      cycles++;
      @(negedge clk);
    end
    check({req, " sweep cycles"}, cycles, exp_len);
    check({req, " done"}, int'(done), 1);
    check({req, " err_wp"}, int'(err_wp), int'(exp_wp));
    check({req, " err_size"}, int'(err_size), int'(exp_sz));
    @(negedge clk);
    check({req, " done one cycle"}, int'(done), 0);
    check({req, " write count"}, wr_count, exp_len);
    if (exp_len > 0) check({req, " base"}, wr_first, exp_base);
    check({req, " write order/data R6"}, wr_bad, 0);
    check_array({req, " array"}, exp_base, exp_len);
  endtask

  task automatic t_unknown();
    prepare();
    req_valid = 1'b1; req_opcode = 8'h03; req_addr = AW'(9'h040); wel = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 busy after unknown opcode", int'(busy), 0);
    check("R11 done after unknown opcode", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R11 writes after unknown opcode", wr_count, 0);
    check_array("R11 array", 0, 0);
  endtask

  task automatic t_overlap();
    int cycles = 0;
    prepare();
    req_valid = 1'b1; req_opcode = 8'hD8; req_addr = AW'(9'h105); wel = 1'b1;
    @(negedge clk);
    req_opcode = 8'hC7;
    req_addr   = AW'(9'h000);
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 1;
    while (busy && cycles < 4000) begin
      cycles++;
      @(negedge clk);
    end
    check("R10 sweep length unchanged", cycles, 128);
    @(negedge clk);
    check("R10 write count", wr_count, 128);
    check("R10 base", wr_first, 9'h100);
    check_array("R10 array", 9'h100, 128);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) mem[i] = 8'h00;
    wr_count = 0; wr_bad = 0; wr_first = -1; wr_prev = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 errors", int'(err_wp | err_size), 0);
    check("R1 mem_we", int'(mem_we), 0);

    run_erase("R2 op20",        8'h20, 9'h07B, 1'b1, 9'h070, 16,  1'b0, 1'b0);
    run_erase("R2 op21",        8'h21, 9'h1F3, 1'b1, 9'h1F0, 16,  1'b0, 1'b0);
    run_erase("R3 R8 op52",     8'h52, 9'h0A5, 1'b1, 9'h080, 64,  1'b0, 1'b1);
    run_erase("R4 R9 opD8",     8'hD8, 9'h0FF, 1'b1, 9'h080, 128, 1'b0, 1'b0);
    run_erase("R4 R9 opDC",     8'hDC, 9'h1C0, 1'b1, 9'h180, 128, 1'b0, 1'b0);
    run_erase("R5 R9 opC7",     8'hC7, 9'h123, 1'b1, 0,      512, 1'b0, 1'b0);
    run_erase("R7 protected",   8'hD8, 9'h010, 1'b0, 0,      0,   1'b1, 1'b0);
    run_erase("R7 R8 prot 52",  8'h52, 9'h010, 1'b0, 0,      0,   1'b1, 1'b1);
    run_erase("R12 after prot", 8'h20, 9'h00F, 1'b1, 9'h000, 16,  1'b0, 1'b0);
    t_unknown();
    t_overlap();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule